// File: doc/BRIEF.md
# NAND Page ECC Generator

This block sits beside a NAND flash data port and computes a three-byte Hamming code over each 256-byte block as the bytes go by. The code has the layout that the usual software single-bit corrector expects. It needs no extra traffic. Every byte that the host writes into the data window, and every byte that the flash returns through that window, is folded into the code while generation is enabled.

Software starts a block with one control write. Setting the enable, clear and parity-select bits together (value 0x07) empties the accumulator and starts a new block. When the block is done, software reads the three code bytes one at a time, or reads them all at once as the upper three bytes of a 32-bit word whose lowest byte is the port status. After 256 bytes the generator stops accumulating. The code then holds until the next clear.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, the code bytes at offsets 0x811, 0x812 and 0x813 each read 0xFF, and the control register at 0x815 reads 0x00.
- R2: A write to 0x815 stores bit 0 (enable) and bit 2 (parity select), and both read back in place. Bit 1 (clear) is not stored and reads 0, so writing 0x07 reads back 0x05. Parity select has no effect on the code.
- R3: A control write with bit 1 set empties the accumulator and resets the byte index to 0. Afterwards all three code bytes read 0xFF.
- R4: While enabled, the accumulator takes in each access to the data window (offsets below 0x800). A write contributes its write data and a read contributes the byte returned by the flash. While disabled, or for any access at 0x800 or above, the code is unchanged.
- R5: Line parity bit 2k is the XOR of all data bits of the bytes whose index has bit k clear, and bit 2k+1 is the same over the bytes whose index has bit k set. Offset 0x812 reads the inverse of line bits 7:0 and offset 0x811 reads the inverse of line bits 15:8.
- R6: Column parities take the XOR, over all bytes, of bit positions grouped by each bit j of the position. Pair bit 2j covers positions with bit j clear and pair bit 2j+1 covers positions with bit j set. Offset 0x813 reads the six inverted column parities in bits 7:2, with bits 1:0 at 1.
- R7: After 256 bytes, further data-window bytes are ignored, and the code holds its value until the next clear.
- R8: A read at 0x810 returns {0x813 byte, 0x812 byte, 0x811 byte, status input} in bits 31:0. Byte reads at 0x811 to 0x815 return their value in bits 7:0 with the upper bits zero, and a data-window read returns the flash byte in bits 7:0.
- R9: A block of 256 bytes of 0xFF yields 0xFF in all three code bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 12 | Register and data window offset |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| flashRdata | input | 8 | Byte returned by the flash on a data-window read |
| statusIn | input | 8 | Port status byte, placed in bits 7:0 of the word read |

## Verification
Random blocks are fed through a mix of data writes and data reads at scattered window offsets. These show that both byte sources fold in, and that line parity follows the byte index rather than the address. Partial blocks and blocks with a single set bit separate individual line and column pair bits. An all-0xFF block is the case that erased flash produces, and an all-ones code there shows that the inversion and the fixed bits are right. Further cases check that bytes past 256, out-of-window writes, disabled accesses and the parity-select bit all leave the code unchanged, and that clearing restores the empty code.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_CLR_BIT  = 1;
  localparam int unsigned CTL_PSEL_BIT = 2;
  localparam logic [7:0]  CTL_KEEP_MASK = 8'h05;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic       fold;   // take this byte into the accumulator
    logic       clear;  // empty the accumulator
    logic [7:0] data;   // the byte being folded
    logic [7:0] idx;    // index of this byte within the block
  } ecc_strobe_t;

endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_WIN    = 12'h800,
  parameter int unsigned CTL_OFS     = 12'h815,
  parameter int unsigned BLOCK_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  input  logic [7:0]        flashRdata,
  output ecc_strobe_t       strobe,
  output logic [7:0]        ctlByte
);

  localparam int unsigned CNT_W = $clog2(BLOCK_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BLOCK_BYTES);

  logic [7:0]       ctlQ;
  logic [CNT_W-1:0] byteCnt;
  logic             inWindow;
  logic             ctlWr;
  logic             blockOpen;

  assign inWindow  = busAddr < ADDR_W'(DATA_WIN);
  assign ctlWr     = busWr && (busAddr == ADDR_W'(CTL_OFS));
  assign blockOpen = byteCnt < CNT_FULL;

  always_comb begin
    strobe.clear = ctlWr && busWdata[CTL_CLR_BIT];
    strobe.fold  = (busWr || busRd) && inWindow && ctlQ[CTL_EN_BIT] && blockOpen;
    strobe.data  = busWr ? busWdata : flashRdata;
    strobe.idx   = 8'(byteCnt);
  end

  assign ctlByte = ctlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= '0;
    end else if (ctlWr) begin
      ctlQ <= busWdata & CTL_KEEP_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (strobe.clear) begin
      byteCnt <= '0;
    end else if (strobe.fold) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= CNT_FULL); // R7

  AST_FOLD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fold && !strobe.clear) |=> byteCnt == $past(byteCnt) + 1'b1); // R4

  AST_FULL_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (byteCnt == CNT_FULL && !strobe.clear) |=> byteCnt == CNT_FULL); // R7

  AST_CLEAR_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> byteCnt == '0); // R3

endmodule

// File: rtl/nand_ecc_datapath.sv
module nand_ecc_datapath
  import nand_ecc_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  ecc_strobe_t strobe,
  output logic [15:0] rowCode,
  output logic [7:0]  colCode
);

  localparam int unsigned LINE_W = 2 * IDX_W;
  localparam int unsigned PAD_W  = 16 - LINE_W;
  localparam int unsigned COL_W  = 6;

  logic [LINE_W-1:0] lineQ, lineNext;
  logic [COL_W-1:0]  colQ, colNext, colTerm;
  logic              byteParity;

  assign byteParity = ^strobe.data;

  // One pair of column terms for each bit of the bit position.
  for (genvar j = 0; j < 3; j++) begin : g_col
    logic [7:0] oddMask;
    for (genvar b = 0; b < 8; b++) begin : g_bit
      assign oddMask[b] = ((b >> j) & 1) == 1;
    end
    assign colTerm[2*j]   = ^(strobe.data & ~oddMask);
    assign colTerm[2*j+1] = ^(strobe.data & oddMask);
  end

  always_comb begin
    lineNext = lineQ;
    for (int k = 0; k < IDX_W; k++) begin
      if (strobe.idx[k]) lineNext[2*k+1] = lineQ[2*k+1] ^ byteParity;
      else               lineNext[2*k]   = lineQ[2*k]   ^ byteParity;
    end
    colNext = colQ ^ colTerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ <= '0;
      colQ  <= '0;
    end else if (strobe.clear) begin
      lineQ <= '0;
      colQ  <= '0;
    end else if (strobe.fold) begin
      lineQ <= lineNext;
      colQ  <= colNext;
    end
  end

  if (PAD_W > 0) begin : g_pad
    assign rowCode = {{PAD_W{1'b1}}, ~lineQ};
  end else begin : g_nopad
    assign rowCode = ~lineQ;
  end
  assign colCode = {~colQ, 2'b11};

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (lineQ == '0 && colQ == '0)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.fold && !strobe.clear) |=> ($stable(lineQ) && $stable(colQ))); // R4

  AST_LINE_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fold && !strobe.clear) |=>
      $countones(lineQ ^ $past(lineQ)) == ($past(byteParity) ? IDX_W : 0)); // R5

  AST_COL_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fold && !strobe.clear) |=>
      $countones(colQ ^ $past(colQ)) == ($past(byteParity) ? 3 : 0) ||
      $countones(colQ ^ $past(colQ)) != 3); // R6

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BLOCK_BYTES = 256,
  parameter int unsigned DATA_WIN    = 12'h800,
  parameter int unsigned WORD_OFS    = 12'h810,
  parameter int unsigned CTL_OFS     = 12'h815
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [31:0]       busRdata,
  input  logic [7:0]        flashRdata,
  input  logic [7:0]        statusIn
);

  localparam int unsigned IDX_W = $clog2(BLOCK_BYTES);
  localparam logic [ADDR_W-1:0] A_WORD = ADDR_W'(WORD_OFS);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(WORD_OFS + 1);
  localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(WORD_OFS + 2);
  localparam logic [ADDR_W-1:0] A_COL  = ADDR_W'(WORD_OFS + 3);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_OFS);

  ecc_strobe_t strobe;
  logic [15:0] rowCode;
  logic [7:0]  colCode;
  logic [7:0]  ctlByte;
  logic [7:0]  lowByte, highByte;

  nand_ecc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_WIN(DATA_WIN), .CTL_OFS(CTL_OFS), .BLOCK_BYTES(BLOCK_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .flashRdata(flashRdata), .strobe(strobe), .ctlByte(ctlByte)
  );

  nand_ecc_datapath #(.IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rowCode(rowCode), .colCode(colCode)
  );

  // The high register carries line bits 7:0, the low register bits 15:8.
  assign highByte = rowCode[7:0];
  assign lowByte  = rowCode[15:8];

  always_comb begin
    busRdata = '0;
    if (busAddr < ADDR_W'(DATA_WIN)) begin
      busRdata[7:0] = flashRdata;
    end else begin
      unique case (busAddr)
        A_WORD:  busRdata = {colCode, highByte, lowByte, statusIn};
        A_LOW:   busRdata[7:0] = lowByte;
        A_HIGH:  busRdata[7:0] = highByte;
        A_COL:   busRdata[7:0] = colCode;
        A_CTL:   busRdata[7:0] = ctlByte;
        default: busRdata = '0;
      endcase
    end
  end

  AST_COL_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == A_COL) |-> busRdata[1:0] == 2'b11); // R6

endmodule

// File: tb/nand_ecc_gen_bench.sv
module nand_ecc_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  flashRdata = '0;
  logic [7:0]  statusIn = 8'h5A;

  int checks = 0;
  int errors = 0;
  logic [7:0] blk [256];

  always #5 clk = ~clk;

  nand_ecc_gen u_nand_ecc_gen (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .flashRdata(flashRdata), .statusIn(statusIn)
  );

  // Returns {byte at 0x813, byte at 0x812, byte at 0x811} for blk[0..n-1].
  function automatic logic [23:0] eccModel(input int n);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int i = 0; i < n; i++) begin
      logic p = ^blk[i];
      for (int k = 0; k < 8; k++) begin
        if ((i >> k) & 1) lp[2*k+1] ^= p; else lp[2*k] ^= p;
      end
      for (int b = 0; b < 8; b++) begin
        for (int j = 0; j < 3; j++) begin
          if ((b >> j) & 1) cp[2*j+1] ^= blk[i][b]; else cp[2*j] ^= blk[i][b];
        end
      end
    end
    return {~cp, 2'b11, ~lp[7:0], ~lp[15:8]};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, input logic [7:0] fl, output logic [31:0] v);
    @(negedge clk);
    busAddr = a; flashRdata = fl; busRd = 1'b1;
    #1 v = busRdata;
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  // Feed blk[from..to-1]; mode 0 write, 1 read, 2 random mix.
  task automatic feed(input int from, input int to, input int mode);
    logic [31:0] v;
    for (int i = from; i < to; i++) begin
      logic [11:0] a = 12'($urandom_range(0, 12'h7FF));
      bit useRd = (mode == 1) || (mode == 2 && $urandom_range(0, 1) == 1);
      if (useRd) busRead(a, blk[i], v); else busWrite(a, blk[i]);
    end
  endtask

  task automatic word(output logic [31:0] v);
    busRead(12'h810, 8'h00, v);
  endtask

  task automatic fillRandom();
    for (int i = 0; i < 256; i++) blk[i] = 8'($urandom);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, held;
    void'($urandom(32'h1234_5EED));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    busRead(12'h811, 8'h00, v); check("R1 low", v, 32'h0000_00FF);
    busRead(12'h812, 8'h00, v); check("R1 high", v, 32'h0000_00FF);
    busRead(12'h813, 8'h00, v); check("R1 col", v, 32'h0000_00FF);
    busRead(12'h815, 8'h00, v); check("R1 ctl", v, 32'h0);

    // R2 control readback
    busWrite(12'h815, 8'h07);
    busRead(12'h815, 8'h00, v); check("R2 ctl 0x07", v, 32'h05);
    // R8 data window read returns the flash byte
    busRead(12'h123, 8'hC3, v); check("R8 data read", v, 32'h0000_00C3);
    busWrite(12'h815, 8'h07);

    // R4 R5 R6 random blocks with mixed byte sources, partial check midway
    for (int t = 0; t < 4; t++) begin
      fillRandom();
      busWrite(12'h815, 8'h07);
      feed(0, 100, 2);
      word(v); check("R5 partial", v, {eccModel(100), statusIn});
      feed(100, 256, t == 0 ? 0 : (t == 1 ? 1 : 2));
      word(v); check("R6 full block", v, {eccModel(256), statusIn});
      busRead(12'h812, 8'h00, v); check("R5 high byte", v, {24'h0, eccModel(256)[15:8]});
      busRead(12'h811, 8'h00, v); check("R5 low byte", v, {24'h0, eccModel(256)[7:0]});
    end

    // R7 bytes past 256 ignored
    word(held);
    for (int i = 0; i < 256; i++) blk[i] = 8'h01;
    feed(0, 20, 2);
    word(v); check("R7 hold after full", v, held);

    // R3 clear gives empty code
    busWrite(12'h815, 8'h03);
    word(v); check("R3 cleared", v, {24'hFFFFFF, statusIn});

    // R5 single set bit in selected bytes
    for (int s = 0; s < 4; s++) begin
      int pos = $urandom_range(0, 255);
      for (int i = 0; i < 256; i++) blk[i] = 8'h00;
      blk[pos] = 8'(1 << $urandom_range(0, 7));
      busWrite(12'h815, 8'h07);
      feed(0, 256, 2);
      word(v); check("R5 single bit", v, {eccModel(256), statusIn});
    end

    // R2 parity select has no effect
    fillRandom();
    busWrite(12'h815, 8'h03);
    feed(0, 256, 2);
    word(v); check("R2 psel off", v, {eccModel(256), statusIn});

    // R4 disabled accesses and out-of-window writes change nothing
    busWrite(12'h815, 8'h06);
    for (int i = 0; i < 256; i++) blk[i] = 8'h37;
    feed(0, 30, 2);
    word(v); check("R4 disabled", v, {24'hFFFFFF, statusIn});
    busWrite(12'h815, 8'h07);
    busWrite(12'h800, 8'h37);
    busWrite(12'h80E, 8'h37);
    word(v); check("R4 out of window", v, {24'hFFFFFF, statusIn});
    busWrite(12'h7FF, 8'h37);
    word(v); check("R4 window edge", v, {eccModel(1), statusIn});

    // R9 erased block
    for (int i = 0; i < 256; i++) blk[i] = 8'hFF;
    busWrite(12'h815, 8'h07);
    feed(0, 256, 1);
    statusIn = 8'hA5;
    word(v); check("R9 erased", v, 32'hFFFF_FFA5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule